// File: doc/BRIEF.md
# Serial EEPROM Read-Path Slave Model

This block is a bit-level model of a two-wire serial EEPROM slave holding 256 bytes. A host samples the clock and data lines of the bus and presents them on `scl_in` and `sda_in`, together with a one-cycle `upd` strobe. Each strobe is one update of the line state. The block compares every sample with the one taken at the previous strobe. From that comparison it recognises start conditions, stop conditions and valid clock rising edges. It returns the data level it drives on `sda_out`, where 1 means the line is released.

A transaction begins with a start. Eight control bits follow, and the last of them chooses read (1) or write (0). The slave acknowledges, eight word-address bits follow, and the slave acknowledges again. At that point the data register is loaded with the byte stored at that address. In a later transaction whose control byte requests a read, the eight clock edges after the acknowledge carry the data register out MSB first. Writing into the array is not modelled.

The contents of the array are computed from two parameters: byte `a` holds `(a * MEM_MUL + MEM_ADD) mod 256`. A single tick counter keeps track of the phases of a transaction.

Top module: `sprom_i2c_slave`

## Requirements
- R1: A start condition sets the tick counter to 1 and clears the command register, also when it arrives in the middle of a transaction. A start is SCL at 1 in the previous and current strobe, with SDA going from 1 to 0. After a start, exactly eight accepted bits are needed before the next acknowledge.
- R2: After reset, and again whenever the tick counter is 0 and no acknowledge is pending, every strobe other than a start is ignored. No acknowledge is driven and `sda_out` stays 1.
- R3: A bit is accepted only on an SCL rising edge: SCL was 0 at the previous strobe and is 1 now. SDA must also be at the same level as at the previous strobe. A rising edge with changed SDA is discarded and does not count as a bit.
- R4: The eight control bits shift into the command register MSB first. After the eighth bit an acknowledge becomes pending. Command bit 0, the last bit received, selects read when 1 and write when 0.
- R5: While an acknowledge is pending, the next SCL rising edge returns `sda_out` = 0 and clears the pending acknowledge. That edge does not shift a bit.
- R6: After the command acknowledge, the next eight accepted bits shift into the word-address register MSB first. After the eighth one, the data register loads the byte at that address, an acknowledge becomes pending and the tick counter returns to 0.
- R7: In a read command, each of the eight address-phase rising edges returns the current MSB of the data register on `sda_out`, and the data register then shifts left by one. The host releases SDA (1) during these edges, so the address that is loaded afterwards is 0xFF.
- R8: In a write command, `sda_out` stays 1 during the address phase, whatever the data register holds.
- R9: `sda_out` is 1 after reset. It changes only on strobes, and it returns to 1 on every strobe that drives neither an acknowledge nor a read data bit.
- R10: The byte at address `a` is `(a * MEM_MUL + MEM_ADD) mod 256`.
- R11: Once the address acknowledge has been driven, further clock edges are ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd | input | 1 | One-cycle strobe: sample `scl_in` and `sda_in` now |
| scl_in | input | 1 | Sampled bus clock level |
| sda_in | input | 1 | Sampled bus data level driven by the host |
| sda_out | output | 1 | Data level driven by the slave (1 = released) |

## Verification
The hardest situations to reach from the ports are those where the tick counter could be miscounted. One is a rising clock edge with a changed data level, which must be discarded. The other is a start arriving halfway through a control byte. The directed tests bring each one about by a single malformed strobe pair in the middle of a control byte. They then show that the acknowledge still arrives after exactly eight further good bits. A current-address read is also reached by chaining transactions: a read phase leaves the data register loaded from address 0xFF, and the next read must return that byte without any address being written.

// File: rtl/sprom_pkg.sv
// Shared types for the serial EEPROM slave model.
package sprom_pkg;

    // One sampled pair of bus line levels.
    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    // Classification of one strobe against the previous one.
    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,  // no clock rise and no start or stop
        EV_START  = 3'd1,  // SCL high in both samples, SDA falls
        EV_STOP   = 3'd2,  // SCL high in both samples, SDA rises
        EV_BIT    = 3'd3,  // SCL rises with SDA unchanged
        EV_GLITCH = 3'd4   // SCL rises while SDA changed
    } line_ev_t;

endpackage

// File: rtl/sprom_line_sampler.sv
// Keeps the line levels seen at the previous strobe and classifies the
// current strobe against them.
// Assumes upd is a one-cycle strobe; ev is meaningful only while upd is 1.
module sprom_line_sampler
    import sprom_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     upd,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);

    line_t prev_q;

    // Hold the levels of the last strobe; both lines start released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '{scl: 1'b1, sda: 1'b1};
        end else if (upd) begin
            prev_q <= '{scl: scl_in, sda: sda_in};
        end
    end

    // Classify the current sample against the previous one.
    always_comb begin
        ev = EV_NONE;
        if (prev_q.scl && scl_in && (prev_q.sda != sda_in)) begin
            ev = sda_in ? EV_STOP : EV_START;
        end else if (!prev_q.scl && scl_in) begin
            ev = (prev_q.sda == sda_in) ? EV_BIT : EV_GLITCH;
        end
    end

endmodule

// File: rtl/sprom_rom.sv
// Read-only byte array whose contents are computed from two parameters:
// cell a holds (a * MEM_MUL + MEM_ADD) truncated to DW bits.
// Assumes a combinational read is acceptable to the caller.
module sprom_rom #(
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int MEM_MUL = 29,
    parameter int MEM_ADD = 60
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Fill every cell from the content formula.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        assign cells[i] = DW'(i * MEM_MUL + MEM_ADD);
    end

    // Combinational read port.
    assign rdata = cells[addr];

endmodule

// File: rtl/sprom_seq.sv
// Transaction sequencer: one tick counter walks the control, address and
// data phases, inserts acknowledges and drives read data onto sda_out.
// Assumes ev comes from sprom_line_sampler and that rom_rdata answers
// rom_addr in the same cycle.
module sprom_seq
    import sprom_pkg::*;
#(
    parameter int CW = 8,
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  line_ev_t      ev,
    input  logic          sda_in,
    input  logic [DW-1:0] rom_rdata,
    output logic [AW-1:0] rom_addr,
    output logic          sda_out
);

    localparam int CMD_DONE = CW + 1;
    localparam int TICK_END = CW + AW + 1;
    localparam int TW       = $clog2(TICK_END + 1);

    logic [TW-1:0] tick_q;
    logic [CW-1:0] cmd_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          ack_q;
    logic          sda_q;
    logic [TW-1:0] tick_inc;
    logic          is_rise;

    assign tick_inc = tick_q + TW'(1);
    assign is_rise  = (ev == EV_BIT) || (ev == EV_GLITCH);
    // The address as it stands once the current bit is shifted in.
    assign rom_addr = {addr_q[AW-2:0], sda_in};
    assign sda_out  = sda_q;

    // Advance the transaction on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            ack_q  <= 1'b0;
            sda_q  <= 1'b1;
        end else if (upd) begin
            sda_q <= 1'b1;
            if (ev == EV_START) begin
                tick_q <= TW'(1);
                cmd_q  <= '0;
            end else if (ev == EV_STOP) begin
                tick_q <= tick_q;
            end else if ((tick_q == '0) && !ack_q) begin
                tick_q <= tick_q;
            end else if (is_rise) begin
                if (ack_q) begin
                    sda_q <= 1'b0;
                    ack_q <= 1'b0;
                end else if (ev == EV_BIT) begin
                    if (tick_q < TW'(CMD_DONE)) begin
                        cmd_q  <= {cmd_q[CW-2:0], sda_in};
                        tick_q <= tick_inc;
                        if (tick_inc == TW'(CMD_DONE)) begin
                            ack_q <= 1'b1;
                        end
                    end else if (tick_q < TW'(TICK_END)) begin
                        if (cmd_q[0]) begin
                            sda_q <= data_q[DW-1];
                        end
                        addr_q <= rom_addr;
                        if (tick_inc == TW'(TICK_END)) begin
                            data_q <= rom_rdata;
                            ack_q  <= 1'b1;
                            tick_q <= '0;
                        end else begin
                            data_q <= {data_q[DW-2:0], 1'b0};
                            tick_q <= tick_inc;
                        end
                    end
                end
            end
        end
    end

    // R1: a start restarts the count with a cleared command
    p_start_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ev == EV_START) |=> (tick_q == TW'(1) && cmd_q == '0));

    // R2: idle strobes other than a start leave the block idle and released
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && tick_q == '0 && !ack_q && ev != EV_START) |=> (tick_q == '0 && sda_out));

    // R3: a rising edge with changed SDA does not advance the count
    p_glitch_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ev == EV_GLITCH && !ack_q) |=> $stable(tick_q));

    // R5: a pending acknowledge is driven low on the next rising edge
    p_ack_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ack_q && is_rise) |=> (!sda_out && !ack_q));

    // R8: a write command never drives data during the address phase
    p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ev == EV_BIT && !ack_q && !cmd_q[0] && tick_q >= TW'(CMD_DONE)) |=> sda_out);

    // R9: the returned level only moves on a strobe
    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(sda_out));

endmodule

// File: rtl/sprom_i2c_slave.sv
// Top level of the serial EEPROM slave model: line sampler, transaction
// sequencer and computed byte array.
// Assumes the host presents sampled bus levels with a one-cycle upd strobe.
module sprom_i2c_slave #(
    parameter int CW      = 8,
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int MEM_MUL = 29,
    parameter int MEM_ADD = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_out
);

    sprom_pkg::line_ev_t ev;
    logic [AW-1:0]       rom_addr;
    logic [DW-1:0]       rom_rdata;

    sprom_line_sampler i_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (upd),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    sprom_seq #(
        .CW (CW),
        .AW (AW),
        .DW (DW)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd),
        .ev        (ev),
        .sda_in    (sda_in),
        .rom_rdata (rom_rdata),
        .rom_addr  (rom_addr),
        .sda_out   (sda_out)
    );

    sprom_rom #(
        .AW      (AW),
        .DW      (DW),
        .MEM_MUL (MEM_MUL),
        .MEM_ADD (MEM_ADD)
    ) i_rom (
        .addr  (rom_addr),
        .rdata (rom_rdata)
    );

endmodule

// File: tb/test_sprom_i2c_slave.sv
// Directed bench for the serial EEPROM slave model.
module test_sprom_i2c_slave;

    localparam int MUL = 29;
    localparam int ADD = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic sda_out;
    int   n_checks = 0;
    int   n_errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    sprom_i2c_slave #(.MEM_MUL(MUL), .MEM_ADD(ADD)) i_sprom_i2c_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .sda_out (sda_out)
    );

    function automatic logic [7:0] exp_mem(input int a);
        return 8'(a * MUL + ADD);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One strobe; sda_out is sampled after the registering edge.
    task automatic strobe(input logic c, input logic d, output logic r);
        @(negedge clk);
        scl_in = c;
        sda_in = d;
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        r = sda_out;
    endtask

    task automatic send_bit(input logic b, output logic r);
        logic x;
        strobe(1'b0, b, x);
        strobe(1'b1, b, r);
    endtask

    task automatic start_cond();
        logic x;
        strobe(1'b0, 1'b1, x);
        strobe(1'b1, 1'b1, x);
        strobe(1'b1, 1'b0, x);
    endtask

    // Send eight bits MSB first; collect the level returned on each rise.
    task automatic send_byte(input logic [7:0] v, output logic [7:0] got);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            send_bit(v[i], r);
            got[i] = r;
        end
    endtask

    task automatic ack_clock(input string req, input logic exp);
        logic r;
        send_bit(1'b1, r);
        check(req, int'(r), int'(exp));
    endtask

    // Full address setup with a write control byte.
    task automatic set_address(input logic [7:0] a, input string req);
        logic [7:0] got;
        start_cond();
        send_byte(8'hA0, got);
        check({req, " R4 control bits released"}, got, 8'hFF);
        ack_clock({req, " R5 control ack"}, 1'b0);
        send_byte(a, got);
        check({req, " R8 write address phase released"}, got, 8'hFF);
        ack_clock({req, " R6 address ack"}, 1'b0);
    endtask

    task automatic read_data(input logic [7:0] exp, input string req);
        logic [7:0] got;
        start_cond();
        send_byte(8'hA1, got);
        check({req, " R4 read control released"}, got, 8'hFF);
        ack_clock({req, " R5 read control ack"}, 1'b0);
        send_byte(8'hFF, got);
        check({req, " R7 R10 read data"}, got, exp);
        ack_clock({req, " R6 ack after read phase"}, 1'b0);
    endtask

    task automatic t_reset();
        check("R9 reset level", int'(sda_out), 1);
    endtask

    task automatic t_idle();
        logic [7:0] got;
        send_byte(8'hA1, got);
        check("R2 bits without start", got, 8'hFF);
        ack_clock("R2 no ack without start", 1'b1);
    endtask

    task automatic t_addr_then_read();
        logic r;
        set_address(8'h5A, "addr 5A");
        strobe(1'b0, 1'b1, r);
        check("R9 release after ack", int'(r), 1);
        read_data(exp_mem(8'h5A), "read 5A");
    endtask

    task automatic t_current();
        read_data(exp_mem(8'hFF), "current FF");
    endtask

    task automatic t_write_quiet_then_read();
        set_address(8'h00, "addr 00 R8");
        read_data(exp_mem(8'h00), "read 00");
    endtask

    task automatic t_after_ack();
        logic [7:0] got;
        set_address(8'h10, "addr 10");
        send_byte(8'h00, got);
        check("R11 ignored after address ack", got, 8'hFF);
        ack_clock("R11 no ack after address ack", 1'b1);
        read_data(exp_mem(8'h10), "read 10");
    endtask

    task automatic t_glitch();
        logic [7:0] got;
        logic r;
        start_cond();
        strobe(1'b0, 1'b0, r);
        strobe(1'b1, 1'b1, r);
        check("R3 glitch rise returns released", int'(r), 1);
        send_byte(8'hA0, got);
        check("R3 glitch not counted as a bit", got, 8'hFF);
        ack_clock("R3 ack after eight good bits", 1'b0);
        send_byte(8'hC3, got);
        ack_clock("R3 address ack", 1'b0);
        read_data(exp_mem(8'hC3), "read C3");
    endtask

    task automatic t_restart();
        logic [7:0] got;
        logic r;
        start_cond();
        for (int i = 0; i < 4; i++) begin
            send_bit(1'b0, r);
        end
        start_cond();
        send_byte(8'hA1, got);
        check("R1 restart needs eight bits", got, 8'hFF);
        ack_clock("R1 ack after restart", 1'b0);
        send_byte(8'hFF, got);
        check("R1 R7 read after restart", got, exp_mem(8'hFF));
        ack_clock("R1 ack after read phase", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_addr_then_read();
        t_current();
        t_write_quiet_then_read();
        t_after_ack();
        t_glitch();
        t_restart();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule